// File: doc/BRIEF.md
# Byte-Stream Packet Protocol Checker

This block sits beside a byte-wide packet stream and watches it without touching it. Each clock the stream presents a start mark, an end mark, a valid qualifier, an error mark and one data byte. The checker follows packet boundaries and counts the valid bytes and elapsed clock cycles of the open packet. It also counts the idle cycles between the close of one packet and the start of the next. From this it classifies eight kinds of protocol violation.

Each class owns one sticky flag bit, whose index equals the class code. A flag stays set until reset or until the clear input is pulsed. Each violation also produces a one-cycle strobe with a 3-bit code. When several classes fire in the same cycle, the lowest code is reported. Length, cycle and gap limits are parameters. The reset is synchronous and active-low.

Top module: `pkt_proto_checker`

## Requirements
- R1: After a clock edge with `rst_n` low, `viol_flags` is 0, `viol_stb` is 0 and `viol_code` is 0.
- R2: A cycle with `mon_err`, `mon_eop` and `mon_valid` all high sets flag bit 0 (code 0, input error).
- R3: A cycle with `mon_sop` high and `mon_valid` low sets flag bit 1 (code 1).
- R4: Flag bit 2 (code 2) is set in either of two cases: `mon_eop` high with `mon_valid` low, or a valid start while a packet is already open. In the second case the open packet is dropped, and byte and cycle counts restart from the new start.
- R5: A valid end that closes a packet holding fewer than MIN_LEN valid bytes sets flag bit 3 (code 3). The start and end beats both count, so a single beat carrying start and end together has length 1.
- R6: A valid end that closes a packet holding more than MAX_LEN valid bytes sets flag bit 4 (code 4).
- R7: A valid end that closes a packet spanning more than MAX_CYC clock cycles sets flag bit 5 (code 5). The span runs from the start cycle to the end cycle inclusive, and cycles without valid are counted.
- R8: A valid start with no packet open, arriving fewer than MIN_GAP cycles after the previous closing valid end, sets flag bit 6 (code 6). The first packet after reset is exempt.
- R9: `mon_err` high on any cycle that is not a valid end sets flag bit 7 (code 7).
- R10: `viol_flags` and the strobe update on the clock edge that samples the offending cycle. In that cycle `viol_stb` is high for exactly one cycle and `viol_code` holds the lowest code that fired. Otherwise `viol_stb` is 0 and `viol_code` is 0.
- R11: Flags never clear except through reset or `clr`. A `clr` sampled high empties all flags, but any class firing in that same cycle is still set.
- R12: `mon_data` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Clears the sticky flags |
| mon_sop | input | 1 | Start-of-packet mark on the watched stream |
| mon_eop | input | 1 | End-of-packet mark on the watched stream |
| mon_valid | input | 1 | Byte qualifier on the watched stream |
| mon_err | input | 1 | Error mark on the watched stream |
| mon_data | input | DATA_W | Data byte; observed only |
| viol_flags | output | 8 | Sticky flag per class; bit index is the class code |
| viol_stb | output | 1 | One-cycle pulse per violating cycle |
| viol_code | output | 3 | Lowest class code that fired with the strobe |

## Verification
The bench builds the checker with MIN_LEN=2, MAX_LEN=8, MAX_CYC=12 and MIN_GAP=2. These small limits put the length and cycle boundaries within a few cycles of stimulus, so both the last passing value and the first failing value are driven for each. A two-cycle gap minimum tests the gap window in the middle, not just the back-to-back case. The data byte is randomized throughout. A random phase mixes all marks and clear pulses against the bench model.

// File: rtl/pkt_chk_pkg.sv
// Package: shared class codes and the mark bundle for the packet checker.
// Assumes the codes double as bit indices of the sticky flag vector.
package pkt_chk_pkg;
    localparam int NUM_CLASS = 8;
    localparam int CODE_W    = 3;

    typedef enum logic [CODE_W-1:0] {
        V_INERR = 3'd0,
        V_SOP   = 3'd1,
        V_EOP   = 3'd2,
        V_SHORT = 3'd3,
        V_LONG  = 3'd4,
        V_CYCLE = 3'd5,
        V_GAP   = 3'd6,
        V_MISER = 3'd7
    } viol_e;

    typedef struct packed {
        logic sop;
        logic eop;
        logic valid;
        logic err;
    } marks_t;
endpackage

// File: rtl/pkt_frame_tracker.sv
// Module: follows packet boundaries on the watched stream, keeps saturating
// byte, cycle and idle-gap counters, and raises the framing-derived events.
// Assumes MIN_GAP >= 1 and MIN_LEN <= MAX_LEN. Events are combinational.
module pkt_frame_tracker
    import pkt_chk_pkg::*;
#(
    parameter int MIN_LEN = 2,
    parameter int MAX_LEN = 64,
    parameter int MAX_CYC = 128,
    parameter int MIN_GAP = 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  marks_t mk,
    output logic   missing_eop,
    output logic   too_short,
    output logic   too_long,
    output logic   over_cycles,
    output logic   gap_short
);
    localparam int LEN_W = $clog2(MAX_LEN + 2);
    localparam int CYC_W = $clog2(MAX_CYC + 2);
    localparam int GAP_W = $clog2(MIN_GAP + 1);
    localparam logic [LEN_W-1:0] LEN_SAT = LEN_W'(MAX_LEN + 1);
    localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_LEN);
    localparam logic [CYC_W-1:0] CYC_SAT = CYC_W'(MAX_CYC + 1);
    localparam logic [CYC_W-1:0] CYC_MAX = CYC_W'(MAX_CYC);
    localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(MIN_GAP);

    logic             open_q;
    logic [LEN_W-1:0] byte_q, len_now;
    logic [CYC_W-1:0] cyc_q, cyc_now;
    logic [GAP_W-1:0] gap_q;
    logic             vsop, veop, closes;

    // Purpose: qualify marks and form the running totals including this beat.
    always_comb begin
        vsop   = mk.sop & mk.valid;
        veop   = mk.eop & mk.valid;
        closes = veop & (open_q | vsop);
        if (vsop) begin
            len_now = LEN_W'(1);
            cyc_now = CYC_W'(1);
        end else begin
            len_now = (mk.valid && byte_q != LEN_SAT) ? byte_q + 1'b1 : byte_q;
            cyc_now = (cyc_q != CYC_SAT) ? cyc_q + 1'b1 : cyc_q;
        end
    end

    // Purpose: derive the framing, length, cycle and gap events.
    always_comb begin
        missing_eop = vsop & open_q;
        too_short   = closes & (len_now < LEN_MIN);
        too_long    = closes & (len_now > LEN_MAX);
        over_cycles = closes & (cyc_now > CYC_MAX);
        gap_short   = vsop & ~open_q & (gap_q < GAP_LIM);
    end

    // Purpose: hold the open state, the counters and the idle-gap count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            byte_q <= '0;
            cyc_q  <= '0;
            gap_q  <= GAP_LIM;
        end else begin
            if (closes) begin
                open_q <= 1'b0;
                gap_q  <= '0;
            end else begin
                if (vsop)
                    open_q <= 1'b1;
                if (!open_q && !vsop && gap_q < GAP_LIM)
                    gap_q <= gap_q + 1'b1;
            end
            if (vsop || open_q) begin
                byte_q <= len_now;
                cyc_q  <= cyc_now;
            end
        end
    end

    // R4: a valid start that does not also end restarts both counts at one.
    a_r4_restart_on_sop: assert property (@(posedge clk) disable iff (!rst_n)
        (vsop && !veop) |=> (open_q && byte_q == LEN_W'(1) && cyc_q == CYC_W'(1)));

    // R8: a closing end always leaves the stream closed with an empty gap count.
    a_r8_gap_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        closes |=> (!open_q && gap_q == '0));
endmodule

// File: rtl/pkt_viol_report.sv
// Module: accumulates per-class events into sticky flags and produces a
// one-cycle strobe with the lowest firing code. Assumes events are one bit
// per class, indexed by code.
module pkt_viol_report
    import pkt_chk_pkg::*;
#(
    parameter int NCLS = NUM_CLASS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [NCLS-1:0]   ev,
    output logic [NCLS-1:0]   flags,
    output logic              stb,
    output logic [$clog2(NCLS)-1:0] code
);
    localparam int CW = $clog2(NCLS);

    logic [CW-1:0] code_n;

    // Purpose: pick the lowest-numbered class that fired this cycle.
    always_comb begin
        code_n = '0;
        for (int i = NCLS - 1; i >= 0; i--)
            if (ev[i]) code_n = CW'(i);
    end

    // Purpose: register sticky flags, strobe and code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
            stb   <= 1'b0;
            code  <= '0;
        end else begin
            flags <= (clr ? '0 : flags) | ev;
            stb   <= |ev;
            code  <= code_n;
        end
    end

    // R11: without a clear no flag ever falls.
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (($past(flags) & ~flags) == '0));

    // R10: a reported code always has its flag raised alongside.
    a_r10_code_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> flags[code]);

    // R10: the code reads zero whenever no strobe is shown.
    a_r10_quiet_code: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |-> (code == '0));
endmodule

// File: rtl/pkt_proto_checker.sv
// Module: top of the passive packet-stream protocol checker. Forms the
// mark-level events, combines them with framing events from the tracker and
// hands all eight to the reporter. Assumes one beat per clock, no backpressure.
module pkt_proto_checker
    import pkt_chk_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int MIN_LEN = 2,
    parameter int MAX_LEN = 64,
    parameter int MAX_CYC = 128,
    parameter int MIN_GAP = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              mon_sop,
    input  logic              mon_eop,
    input  logic              mon_valid,
    input  logic              mon_err,
    input  logic [DATA_W-1:0] mon_data,
    output logic [7:0]        viol_flags,
    output logic              viol_stb,
    output logic [2:0]        viol_code
);
    marks_t               mk;
    logic [NUM_CLASS-1:0] ev;
    logic                 missing_eop, too_short, too_long, over_cycles, gap_short;
    logic                 data_unused;

    assign mk          = {mon_sop, mon_eop, mon_valid, mon_err};
    assign data_unused = ^mon_data;

    pkt_frame_tracker #(
        .MIN_LEN (MIN_LEN),
        .MAX_LEN (MAX_LEN),
        .MAX_CYC (MAX_CYC),
        .MIN_GAP (MIN_GAP)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .mk          (mk),
        .missing_eop (missing_eop),
        .too_short   (too_short),
        .too_long    (too_long),
        .over_cycles (over_cycles),
        .gap_short   (gap_short)
    );

    // Purpose: assemble the per-class event vector indexed by class code.
    always_comb begin
        ev          = '0;
        ev[V_INERR] = mk.err & mk.eop & mk.valid;
        ev[V_SOP]   = mk.sop & ~mk.valid;
        ev[V_EOP]   = (mk.eop & ~mk.valid) | missing_eop;
        ev[V_SHORT] = too_short;
        ev[V_LONG]  = too_long;
        ev[V_CYCLE] = over_cycles;
        ev[V_GAP]   = gap_short;
        ev[V_MISER] = mk.err & ~(mk.eop & mk.valid);
    end

    pkt_viol_report #(
        .NCLS (NUM_CLASS)
    ) u_rep (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .ev    (ev),
        .flags (viol_flags),
        .stb   (viol_stb),
        .code  (viol_code)
    );

    // R3: a start without valid shows up in flag bit 1 on the next cycle.
    a_r3_sop_novalid: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_sop && !mon_valid) |=> viol_flags[1]);

    // R2: an error on a valid end raises flag bit 0 and a strobe with code 0.
    a_r2_input_error: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_err && mon_eop && mon_valid) |=> (viol_flags[0] && viol_stb && viol_code == 3'd0));

    // R9: an error outside a valid end raises flag bit 7.
    a_r9_misplaced: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_err && !(mon_eop && mon_valid)) |=> viol_flags[7]);
endmodule

// File: tb/sim_pkt_proto_checker.sv
module sim_pkt_proto_checker;
    localparam int CLK_PERIOD = 10;
    localparam int MIN_LEN = 2;
    localparam int MAX_LEN = 8;
    localparam int MAX_CYC = 12;
    localparam int MIN_GAP = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       sop = 1'b0, eop = 1'b0, vld = 1'b0, err = 1'b0;
    logic [7:0] data = 8'h00;
    logic [7:0] viol_flags;
    logic       viol_stb;
    logic [2:0] viol_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // reference model state
    int         m_open, m_bytes, m_cycs, m_gap;
    logic [7:0] m_flags;
    bit         m_stb;
    int         m_code;

    pkt_proto_checker #(
        .DATA_W  (8),
        .MIN_LEN (MIN_LEN),
        .MAX_LEN (MAX_LEN),
        .MAX_CYC (MAX_CYC),
        .MIN_GAP (MIN_GAP)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .mon_sop    (sop),
        .mon_eop    (eop),
        .mon_valid  (vld),
        .mon_err    (err),
        .mon_data   (data),
        .viol_flags (viol_flags),
        .viol_stb   (viol_stb),
        .viol_code  (viol_code)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_open = 0; m_bytes = 0; m_cycs = 0; m_gap = MIN_GAP;
        m_flags = '0; m_stb = 0; m_code = 0;
    endtask

    // One cycle of the expected behaviour, from the requirements.
    task automatic model_step(input bit s, input bit e, input bit v, input bit r, input bit c);
        logic [7:0] ev;
        bit vs, ve;
        ev = '0;
        vs = s && v;
        ve = e && v;
        if (ve && r) ev[0] = 1;
        if (s && !v) ev[1] = 1;
        if (e && !v) ev[2] = 1;
        if (vs && m_open != 0) ev[2] = 1;
        if (vs) begin
            if (m_open == 0 && m_gap < MIN_GAP) ev[6] = 1;
            m_open = 1; m_bytes = 1; m_cycs = 1;
        end else if (m_open != 0) begin
            m_cycs++;
            if (v) m_bytes++;
        end
        if (ve && m_open != 0) begin
            if (m_bytes < MIN_LEN) ev[3] = 1;
            if (m_bytes > MAX_LEN) ev[4] = 1;
            if (m_cycs > MAX_CYC) ev[5] = 1;
            m_open = 0;
            m_gap = 0;
        end else if (m_open == 0 && !vs) begin
            m_gap++;
        end
        if (r && !ve) ev[7] = 1;
        m_flags = (c ? 8'h00 : m_flags) | ev;
        m_stb = |ev;
        m_code = 0;
        for (int i = 7; i >= 0; i--) if (ev[i]) m_code = i;
    endtask

    // Drive one beat, let the edge pass, then compare against the model.
    task automatic beat(input bit s, input bit e, input bit v, input bit r, input bit c);
        @(negedge clk);
        sop = s; eop = e; vld = v; err = r; clr = c;
        data = 8'($urandom);
        @(posedge clk);
        model_step(s, e, v, r, c);
        #1;
        chk(viol_flags == m_flags && viol_stb == m_stb && int'(viol_code) == m_code,
            "R10 R11 per-cycle flags/strobe/code",
            {viol_flags, 3'b0, viol_stb, 1'b0, viol_code},
            {m_flags, 3'b0, m_stb, 1'b0, 3'(m_code)});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) beat(0, 0, 0, 0, 0);
    endtask

    task automatic clear();
        beat(0, 0, 0, 0, 1);
    endtask

    // Packet of nb valid bytes with ns stall cycles after the start beat.
    task automatic pkt(input int nb, input int ns, input bit err_end);
        if (nb == 1) begin
            beat(1, 1, 1, err_end, 0);
        end else begin
            beat(1, 0, 1, 0, 0);
            for (int i = 0; i < ns; i++) beat(0, 0, 0, 0, 0);
            for (int i = 0; i < nb - 2; i++) beat(0, 0, 1, 0, 0);
            beat(0, 1, 1, err_end, 0);
        end
    endtask

    task automatic expect_flags(input logic [7:0] exp, input string tag);
        chk(viol_flags == exp, tag, viol_flags, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk(viol_flags == 8'h00 && viol_stb == 1'b0 && viol_code == 3'd0,
            "R1 reset state", {viol_flags, viol_stb, viol_code}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R12: clean packet with random data raises nothing
        idle(3);
        pkt(4, 0, 0);
        expect_flags(8'h00, "R12 clean packet, data ignored");

        // R5: single-beat packet is too short; two bytes is fine
        idle(3);
        pkt(1, 0, 0);
        expect_flags(8'h08, "R5 length 1 too short");
        clear();
        idle(2);
        pkt(2, 0, 0);
        expect_flags(8'h00, "R5 length 2 accepted");

        // R6: MAX_LEN passes, MAX_LEN+1 fails
        idle(2);
        pkt(MAX_LEN, 0, 0);
        expect_flags(8'h00, "R6 length at limit accepted");
        idle(2);
        pkt(MAX_LEN + 1, 0, 0);
        expect_flags(8'h10, "R6 length over limit");
        clear();

        // R7: 4 bytes + 8 stalls = 12 cycles passes, + 9 stalls fails
        idle(2);
        pkt(4, MAX_CYC - 4, 0);
        expect_flags(8'h00, "R7 cycles at limit accepted");
        idle(2);
        pkt(4, MAX_CYC - 3, 0);
        expect_flags(8'h20, "R7 cycles over limit");
        clear();

        // R8: one idle cycle is below MIN_GAP=2, two are enough
        idle(2);
        pkt(3, 0, 0);
        idle(1);
        pkt(3, 0, 0);
        expect_flags(8'h40, "R8 gap of one below minimum");
        clear();
        idle(2);
        pkt(3, 0, 0);
        idle(2);
        pkt(3, 0, 0);
        expect_flags(8'h00, "R8 gap at minimum accepted");

        // R3: start without valid
        idle(2);
        beat(1, 0, 0, 0, 0);
        expect_flags(8'h02, "R3 start without valid");
        chk(viol_stb && viol_code == 3'd1, "R10 strobe code 1", viol_code, 1);
        clear();

        // R4: end without valid, then a restart that must not count old bytes
        idle(2);
        beat(0, 1, 0, 0, 0);
        expect_flags(8'h04, "R4 end without valid");
        clear();
        idle(2);
        pkt(6, 0, 0);
        expect_flags(8'h00, "R4 prep packet");
        idle(2);
        beat(1, 0, 1, 0, 0);
        for (int i = 0; i < 5; i++) beat(0, 0, 1, 0, 0);
        beat(1, 0, 1, 0, 0);
        beat(0, 0, 1, 0, 0);
        beat(0, 0, 1, 0, 0);
        beat(0, 1, 1, 0, 0);
        expect_flags(8'h04, "R4 start inside packet, counts restarted");
        clear();

        // R2: error on valid end
        idle(2);
        pkt(3, 0, 1);
        expect_flags(8'h01, "R2 input error on end");
        chk(viol_code == 3'd0 && viol_stb, "R2 code 0", viol_code, 0);
        clear();

        // R9: error on a middle byte
        idle(2);
        beat(1, 0, 1, 0, 0);
        beat(0, 0, 1, 1, 0);
        expect_flags(8'h80, "R9 misplaced error");
        beat(0, 1, 1, 0, 0);
        clear();

        // R10: end without valid plus error -> codes 2 and 7, lowest wins
        idle(2);
        beat(0, 1, 0, 1, 0);
        chk(viol_stb && viol_code == 3'd2, "R10 lowest code wins", viol_code, 2);
        expect_flags(8'h84, "R10 both flags set");
        beat(0, 0, 0, 0, 0);
        chk(!viol_stb && viol_code == 3'd0, "R10 strobe one cycle", viol_stb, 0);

        // R11: flags hold, then clear with a same-cycle event keeps only that one
        idle(5);
        expect_flags(8'h84, "R11 flags held");
        beat(1, 0, 0, 0, 1);
        expect_flags(8'h02, "R11 clear with simultaneous event");
        clear();
        expect_flags(8'h00, "R11 clear empties flags");

        // random mix against the model
        idle(3);
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            beat(r < 12, (r % 9) == 0, ($urandom_range(0, 3) != 0),
                 ($urandom_range(0, 29) == 0), ($urandom_range(0, 49) == 0));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule